// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker

This block sits between a framebuffer fetch engine and a palette or colour pipeline. It accepts 32-bit framebuffer words over a valid/ready handshake and emits one pixel per clock from the word it holds. The configured colour depth sets how many pixels each word carries: 32, 16, 8, 4, 2 or 1. At 1, 2, 4 and 8 bits per pixel the output is a palette index. At 16 and 32 bits per pixel the output is a direct colour expanded to 8 bits per channel.

Two ordering flags control where each pixel is taken from in the word. A byte flag selects fully big-endian consumption and overrides a pixel-order flag. The pixel-order flag reverses the order of sub-byte pixels within each byte. A swap flag exchanges the red and blue channels of direct colour. The block counts pixels along a line and strobes end of line on the last one. The unused remainder of the current word is then dropped, so every line starts on a fresh word. It also reports the byte length of a line for the configured width and depth. Memory fetch, palette lookup and display timing are handled elsewhere.

Top module: `fb_unpack`

## Requirements
- R1: Depth code 0,1,2,3,4,5 selects 1,2,4,8,16,32 bits per pixel; codes 6 and 7 behave as 32. In index modes (codes 0..3) `pix_data[7:0]` carries the index and bits 23:8 are zero.
- R2: `line_bytes` equals `line_px` shifted right by 3, 2 or 1 for codes 0, 1 and 2, is equal to `line_px` for code 3, and is `line_px` shifted left by 1 or 2 for codes 4 and 5.
- R3: With both ordering flags clear, bytes are used from bits 7:0 upward. Sub-byte pixels are taken from the low bits of each byte first. 16-bit pixels come from bits 15:0 and then from bits 31:16.
- R4: With only `pix_msb_first` set, bytes are still used from bits 7:0 upward, but sub-byte pixels are taken from the high bits of each byte first. At 8 bits per pixel and above, the flag has no effect.
- R5: With `byte_be` set, pixels are taken from the most significant end of the word downward at every depth (first byte is bits 31:24, first 16-bit pixel is bits 31:16). `pix_msb_first` is then ignored.
- R6: A 16-bit pixel holds red in bits 4:0, green in 9:5 and blue in 14:10. Bit 15 is ignored. Each channel is output as its 5-bit value shifted left by 3.
- R7: A 32-bit pixel holds red in bits 7:0, green in 15:8 and blue in 23:16. Bits 31:24 are ignored. Direct colour is output as red in `pix_data[23:16]`, green in 15:8 and blue in 7:0.
- R8: `rb_swap` exchanges the red and blue output fields for direct colour and has no effect on index output.
- R9: Pixels are produced and words accepted only while both `en` and `pwr` are high. Dropping either one discards the held word and restarts the line count.
- R10: `pix_eol` is high with the `line_px`-th pixel of each line. The rest of that word is dropped, and the next line starts at pixel 0 of a newly accepted word.
- R11: While words are offered without gaps, one pixel is emitted every cycle. `in_ready` is high only when no pixel remains to be emitted after the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Unpacker enable |
| pwr | input | 1 | Power-up qualifier, ANDed with `en` |
| depth | input | 3 | Colour depth code |
| byte_be | input | 1 | Big-endian byte consumption (takes priority) |
| pix_msb_first | input | 1 | Sub-byte pixels from the high bits first |
| rb_swap | input | 1 | Swap red and blue in direct colour |
| line_px | input | CNT_W | Pixels per line (at least 1) |
| line_bytes | output | CNT_W+2 | Bytes per line for this depth |
| in_word | input | 32 | Framebuffer word |
| in_valid | input | 1 | `in_word` is valid |
| in_ready | output | 1 | Word accepted when high with `in_valid` |
| pix_valid | output | 1 | A pixel is present on `pix_data` |
| pix_data | output | 24 | Palette index or RGB 8:8:8 |
| pix_eol | output | 1 | Last pixel of the line |

## Verification
A wrong slot counter or ordering mask shows up at once as a mis-ordered pixel value on `pix_data` in the same cycle, so the reference stream comparison catches it on the first differing pixel. A wrong line count first shows up as a misplaced `pix_eol`. Every pixel after that point then comes from the wrong word, so the error spreads within one line. A held word that is not dropped on disable shows up as a stale pixel on the first pixel after re-enable.

// File: rtl/fb_unpack.sv
module fb_unpack #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pwr,
  input  logic [2:0]       depth,
  input  logic             byte_be,
  input  logic             pix_msb_first,
  input  logic             rb_swap,
  input  logic [CNT_W-1:0] line_px,
  output logic [CNT_W+1:0] line_bytes,
  input  logic [31:0]      in_word,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             pix_valid,
  output logic [23:0]      pix_data,
  output logic             pix_eol
);
  localparam int LW = CNT_W + 2;

  logic             active;
  logic [2:0]       dsel;
  logic [5:0]       bw;
  logic [31:0]      word_q;
  logic             full_q;
  logic [4:0]       slot_q;
  logic [CNT_W-1:0] pcnt_q;
  logic [5:0]       next_pos, base_pos, flip;
  logic [4:0]       off;
  logic [31:0]      sh;
  logic             last, eol;
  logic [7:0]       r, g, b, m8;

  assign active   = en & pwr;
  assign dsel     = (depth > 3'd5) ? 3'd5 : depth;
  assign bw       = 6'd1 << dsel;
  assign next_pos = ({1'b0, slot_q} + 6'd1) << dsel;
  assign base_pos = {1'b0, slot_q} << dsel;
  assign flip     = byte_be ? (6'd32 - bw)
                  : (pix_msb_first && dsel < 3'd3) ? (6'd8 - bw) : 6'd0;
  assign off      = base_pos[4:0] ^ flip[4:0];
  assign sh       = word_q >> off;
  assign last     = (next_pos == 6'd32);
  assign eol      = (pcnt_q == line_px - CNT_W'(1));

  assign pix_valid = full_q & active;
  assign pix_eol   = pix_valid & eol;
  assign in_ready  = active & (~full_q | last | eol);

  assign line_bytes = (dsel < 3'd3) ? (LW'(line_px) >> (3'd3 - dsel))
                                    : (LW'(line_px) << (dsel - 3'd3));

  always_comb begin
    case (dsel)
      3'd0:    m8 = 8'h01;
      3'd1:    m8 = 8'h03;
      3'd2:    m8 = 8'h0f;
      default: m8 = 8'hff;
    endcase
    if (dsel == 3'd4) begin
      r = {sh[4:0], 3'b000};
      g = {sh[9:5], 3'b000};
      b = {sh[14:10], 3'b000};
    end else begin
      r = sh[7:0];
      g = sh[15:8];
      b = sh[23:16];
    end
    if (dsel < 3'd4)    pix_data = {16'h0000, sh[7:0] & m8};
    else if (rb_swap)   pix_data = {b, g, r};
    else                pix_data = {r, g, b};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      full_q <= 1'b0;
      slot_q <= '0;
      pcnt_q <= '0;
      word_q <= '0;
    end else if (full_q) begin
      pcnt_q <= eol ? '0 : pcnt_q + CNT_W'(1);
      if (last || eol) begin
        slot_q <= '0;
        full_q <= in_valid;
        if (in_valid) word_q <= in_word;
      end else begin
        slot_q <= slot_q + 5'd1;
      end
    end else if (in_valid) begin
      full_q <= 1'b1;
      slot_q <= '0;
      word_q <= in_word;
    end
  end
endmodule

// File: rtl/fb_unpack_chk.sv
module fb_unpack_chk #(
  parameter int CNT_W = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        pwr,
  input logic [2:0]  depth,
  input logic        in_valid,
  input logic        in_ready,
  input logic        pix_valid,
  input logic [23:0] pix_data,
  input logic        pix_eol
);
  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || !pwr) |=> !pix_valid);

  assert_index_zero_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && depth <= 3'd3) |-> (pix_data[23:8] == 16'h0000));

  assert_rgb16_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && depth == 3'd4) |->
      (pix_data[2:0] == 3'b000 && pix_data[10:8] == 3'b000 && pix_data[18:16] == 3'b000));

  assert_eol_with_pixel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eol |-> pix_valid);

  assert_word_not_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !in_ready) |=> (pix_valid || !(en && pwr)));

  assert_accept_gives_pixel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (pix_valid || !(en && pwr)));
endmodule

bind fb_unpack fb_unpack_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pwr(pwr), .depth(depth),
  .in_valid(in_valid), .in_ready(in_ready), .pix_valid(pix_valid),
  .pix_data(pix_data), .pix_eol(pix_eol)
);

// File: tb/tb_fb_unpack.sv
module tb_fb_unpack;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0, pwr = 1'b0;
  logic [2:0]       depth = 3'd0;
  logic             byte_be = 1'b0, pix_msb_first = 1'b0, rb_swap = 1'b0;
  logic [CNT_W-1:0] line_px = 12'd8;
  logic [CNT_W+1:0] line_bytes;
  logic [31:0]      in_word = '0;
  logic             in_valid = 1'b0;
  logic             in_ready, pix_valid, pix_eol;
  logic [23:0]      pix_data;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fb_unpack #(.CNT_W(CNT_W)) dut (.*);

  initial begin
    #(5 * 150000);
    fails = fails + 1;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(int n, int seed);
    logic [31:0] v;
    v = (32'(n) * 32'h9e3779b1) ^ (32'(n) << 7) ^ 32'(seed * 32'h01000193);
    return v ^ (v >> 13);
  endfunction

  function automatic logic [23:0] expect_px(logic [31:0] w, int k, int d,
                                            bit bb, bit bp, bit sw);
    int bits, per, bi, j;
    logic [7:0] by, r, g, b;
    logic [15:0] h;
    if (d > 5) d = 5;
    bits = 1 << d;
    if (bits < 8) begin
      per = 8 / bits;
      bi = k / per;
      j = k % per;
      by = bb ? w[8*(3-bi) +: 8] : w[8*bi +: 8];
      if (bb || bp) by = by >> (8 - bits * (j + 1));
      else          by = by >> (bits * j);
      return {16'h0, by & 8'((1 << bits) - 1)};
    end
    if (bits == 8) return {16'h0, bb ? w[8*(3-k) +: 8] : w[8*k +: 8]};
    if (bits == 16) begin
      h = bb ? w[16*(1-k) +: 16] : w[16*k +: 16];
      r = {h[4:0], 3'b0}; g = {h[9:5], 3'b0}; b = {h[14:10], 3'b0};
    end else begin
      r = w[7:0]; g = w[15:8]; b = w[23:16];
    end
    return sw ? {b, g, r} : {r, g, b};
  endfunction

  task automatic run(string req, int d, bit bb, bit bp, bit sw,
                     int npx, int nlines, bit gaps, int seed);
    logic [23:0] eq[$];
    bit          ee[$];
    int per, wpl, widx, got, lim, dd;
    bit take;
    dd = (d > 5) ? 5 : d;
    per = 32 >> dd;
    wpl = (npx + per - 1) / per;
    for (int l = 0; l < nlines; l++)
      for (int k = 0; k < npx; k++) begin
        eq.push_back(expect_px(gen(l * wpl + k / per, seed), k % per, d, bb, bp, sw));
        ee.push_back(k == npx - 1);
      end
    @(posedge clk); #1;
    depth = 3'(d); byte_be = bb; pix_msb_first = bp; rb_swap = sw;
    line_px = CNT_W'(npx);
    widx = 0; got = 0; lim = 0;
    in_word = gen(0, seed); in_valid = 1'b1;
    en = 1'b1; pwr = 1'b1;
    while (eq.size() > 0 && lim < 4000) begin
      @(negedge clk);
      lim++;
      take = in_valid && in_ready;
      if (pix_valid) begin
        chk(req, {8'h0, pix_data}, {8'h0, eq[0]});
        chk("R10", {31'h0, pix_eol}, {31'h0, ee[0]});
        void'(eq.pop_front()); void'(ee.pop_front());
        got++;
      end
      @(posedge clk); #1;
      if (take) begin
        widx++;
        in_word = gen(widx, seed);
      end
      in_valid = gaps ? ((lim % 5) != 3) : 1'b1;
    end
    chk({req, " count"}, 32'(eq.size()), 0);
    chk("R11 words", 32'(widx >= wpl * nlines), 1);
    in_valid = 1'b0; en = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset valid", {31'h0, pix_valid}, 0);
    chk("R9 reset ready", {31'h0, in_ready}, 0);
    chk("R10 reset eol", {31'h0, pix_eol}, 0);

    line_px = 12'd24;
    for (int d = 0; d < 8; d++) begin
      depth = 3'(d);
      #1;
      case (d)
        0: chk("R2 1bpp", 32'(line_bytes), 3);
        1: chk("R2 2bpp", 32'(line_bytes), 6);
        2: chk("R2 4bpp", 32'(line_bytes), 12);
        3: chk("R2 8bpp", 32'(line_bytes), 24);
        4: chk("R2 16bpp", 32'(line_bytes), 48);
        default: chk("R1 R2 32bpp", 32'(line_bytes), 96);
      endcase
    end

    // power low with enable high: still idle
    en = 1'b1; pwr = 1'b0; in_valid = 1'b1; in_word = 32'hdeadbeef;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 pwr low valid", {31'h0, pix_valid}, 0);
    chk("R9 pwr low ready", {31'h0, in_ready}, 0);
    en = 1'b0; in_valid = 1'b0;

    // throughput: no gaps, check continuous output
    depth = 3'd4; line_px = 12'd8; byte_be = 0; pix_msb_first = 0; rb_swap = 0;
    in_valid = 1'b1; in_word = 32'h12345678;
    en = 1'b1; pwr = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R11 one per cycle", {31'h0, pix_valid}, 1);
    end
    // disable mid-line, then restart: first pixel comes from fresh word
    en = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1;
    in_word = 32'h0000_7c1f; in_valid = 1'b1; en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 restart", {8'h0, pix_data}, {8'h0, 24'hf800f8});
    en = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1;

    run("R3 1bpp le",   0, 0, 0, 0, 40, 3, 0, 1);
    run("R4 1bpp msb",  0, 0, 1, 0, 32, 2, 1, 2);
    run("R5 1bpp prio", 0, 1, 1, 0, 40, 2, 0, 3);
    run("R3 2bpp le",   1, 0, 0, 0, 20, 3, 1, 4);
    run("R4 4bpp msb",  2, 0, 1, 0, 11, 3, 0, 5);
    run("R5 8bpp be",   3, 1, 0, 0, 6, 4, 1, 6);
    run("R4 8bpp noeff",3, 0, 1, 0, 7, 3, 0, 7);
    run("R6 16bpp",     4, 0, 0, 0, 5, 3, 1, 8);
    run("R8 16bpp swap",4, 1, 0, 1, 6, 2, 0, 9);
    run("R7 32bpp",     5, 0, 0, 0, 4, 3, 0, 10);
    run("R8 32bpp swap",5, 0, 0, 1, 4, 2, 1, 11);
    run("R1 code7",     7, 0, 0, 0, 3, 2, 0, 12);
    run("R8 index swap",3, 0, 0, 1, 8, 2, 0, 13);
    run("R10 len1",     2, 0, 0, 0, 1, 5, 0, 14);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule